// File: doc/BRIEF.md
# Zero-Gap Overlap-Add Pitch-Up Stage

This block stretches a sample stream in time as the first half of an upward pitch shift. Incoming samples arrive on a slow input strobe and are collected into fixed windows of `WIN_LEN` samples in a two-bank buffer. Once a window is complete it is played out on a faster output strobe that the block makes itself. After the last sample of the window, the stage emits zero samples until the next window has been fully collected. This produces a stream of windows with a short zero gap between each pair.

That gapped stream is then added to a copy of itself, delayed by `GAP = WIN_LEN*(100-OVERLAP_PCT)/100` output samples. Each window therefore overlaps its own shifted image, and the sum is saturated to 16 bits. The output strobe fires `WIN_LEN+GAP` times for every `WIN_LEN` input strobes. This comes from a fractional credit accumulator, so every window occupies a slot of exactly `WIN_LEN+GAP` output samples. A flag on each output sample tells whether the undelayed term came from stored data or from zero padding. A resampler downstream restores the original duration.

Top module: `pitchup_stage`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is 0, `out_sample` is 0 and `out_from_mem` is 0.
- R2: A sample is stored only on a cycle where `in_valid` is 1. The value on `in_sample` in any other cycle has no effect on any later output.
- R3: Every `WIN_LEN` accepted input samples give exactly `WIN_LEN+GAP` output strobes. `out_valid` is a one-cycle pulse per output sample. Input strobes must be at least 3 clock cycles apart.
- R4: A completed window is played out in arrival order, starting at the first output strobe after its last sample was stored. Exactly `WIN_LEN` consecutive outputs carry `out_from_mem`=1 for it.
- R5: Between windows, the undelayed term is zero and `out_from_mem`=0 until the next window is complete. With windows fed back to back, each gap is exactly `GAP` outputs long (4 with the defaults).
- R6: Each output equals the current gapped-stream value plus the gapped-stream value `GAP` output strobes earlier. The delayed term is zero for the first `GAP` outputs after reset.
- R7: The sum saturates to the signed 16-bit range: it clamps to 32767 above and to -32768 below, and never wraps.
- R8: A reset in the middle of a window discards its samples. The next window collected after reset starts from its first sample, and no output before it carries stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe |
| in_sample | input | 16 | Signed input sample |
| out_valid | output | 1 | Output sample strobe, generated internally |
| out_sample | output | 16 | Signed saturated overlap-add output |
| out_from_mem | output | 1 | 1 when the undelayed term of this output came from a stored window |

## Verification
The hardest case to reach is the boundary between one window and the next. The last stored samples of one window are summed with the zero gap and with the delayed tail of the previous window. At the same moment the slot timing has to land exactly on `GAP` zeros. The stimulus feeds windows back to back, with ramps that differ from window to window, so that any slip at the boundary changes the value and the flag of specific outputs. Windows of constant full-scale values of either sign push the overlap sum past both rails. A reset in the middle of a window, followed by fresh windows, shows that the partial data is discarded.

// File: rtl/pitchup_pkg.sv
`timescale 1ns/1ps
package pitchup_pkg;

    localparam int SMP_W = 16;

    typedef logic signed [SMP_W-1:0] smp_t;

    typedef struct packed {
        logic from_mem;
        smp_t val;
    } tap_t;

    localparam smp_t SMP_MAX = {1'b0, {(SMP_W-1){1'b1}}};
    localparam smp_t SMP_MIN = {1'b1, {(SMP_W-1){1'b0}}};

    function automatic int gap_len(input int win, input int pct);
        return (win * (100 - pct)) / 100;
    endfunction

    function automatic smp_t sat_add(input smp_t a, input smp_t b);
        logic [SMP_W:0] wide;
        wide = {a[SMP_W-1], a} + {b[SMP_W-1], b};
        if (wide[SMP_W] != wide[SMP_W-1])
            return wide[SMP_W] ? SMP_MIN : SMP_MAX;
        return smp_t'(wide[SMP_W-1:0]);
    endfunction

endpackage

// File: rtl/pu_tick_gen.sv
`timescale 1ns/1ps
module pu_tick_gen #(
    parameter int WIN = 16,
    parameter int GAP = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid_i,
    output logic tick_o
);
    localparam int ACC_W = $clog2(2*WIN + GAP + 1) + 1;
    localparam logic [ACC_W-1:0] ADD_STEP = ACC_W'(WIN + GAP);
    localparam logic [ACC_W-1:0] SUB_STEP = ACC_W'(WIN);

    logic [ACC_W-1:0] credit;

    assign tick_o = (credit >= SUB_STEP);

    always_ff @(posedge clk) begin
        if (rst) begin
            credit <= '0;
        end else begin
            credit <= credit + (in_valid_i ? ADD_STEP : '0) - (tick_o ? SUB_STEP : '0);
        end
    end

    AST_CREDIT_DRAINED: assert property (@(posedge clk) disable iff (rst)
        in_valid_i |-> (credit < SUB_STEP)); // R3

endmodule

// File: rtl/pu_window_store.sv
`timescale 1ns/1ps
module pu_window_store
    import pitchup_pkg::*;
#(
    parameter int WIN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid_i,
    input  smp_t in_sample_i,
    input  logic tick_i,
    output tap_t tap_o
);
    localparam int IDX_W = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int DEPTH = 2 ** (IDX_W + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WIN - 1);

    smp_t mem [DEPTH];

    logic [IDX_W-1:0] wr_idx;
    logic             wr_bank;
    logic             pending;
    logic             pend_bank;
    logic             rd_active;
    logic [IDX_W-1:0] rd_idx;
    logic             rd_bank;

    logic             last_wr;
    logic             start_rd;
    logic [IDX_W:0]   rd_addr;

    assign last_wr  = in_valid_i && (wr_idx == LAST_IDX);
    assign start_rd = tick_i && !rd_active && pending;
    assign rd_addr  = rd_active ? {rd_bank, rd_idx} : {pend_bank, {IDX_W{1'b0}}};

    always_comb begin
        tap_o.from_mem = tick_i && (rd_active || pending);
        tap_o.val      = tap_o.from_mem ? mem[rd_addr] : '0;
    end

    always_ff @(posedge clk) begin
        if (in_valid_i) begin
            mem[{wr_bank, wr_idx}] <= in_sample_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_idx    <= '0;
            wr_bank   <= 1'b0;
            pending   <= 1'b0;
            pend_bank <= 1'b0;
        end else begin
            if (in_valid_i) begin
                if (last_wr) begin
                    wr_idx  <= '0;
                    wr_bank <= ~wr_bank;
                end else begin
                    wr_idx <= wr_idx + 1'b1;
                end
            end
            if (last_wr) begin
                pending   <= 1'b1;
                pend_bank <= wr_bank;
            end else if (start_rd) begin
                pending <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_active <= 1'b0;
            rd_idx    <= '0;
            rd_bank   <= 1'b0;
        end else if (tick_i) begin
            if (rd_active) begin
                if (rd_idx == LAST_IDX) begin
                    rd_active <= 1'b0;
                    rd_idx    <= '0;
                end else begin
                    rd_idx <= rd_idx + 1'b1;
                end
            end else if (pending) begin
                rd_active <= (WIN > 1);
                rd_idx    <= IDX_W'(1);
                rd_bank   <= pend_bank;
            end
        end
    end

    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (rst)
        last_wr |-> !pending); // R4

endmodule

// File: rtl/pu_overlap_add.sv
`timescale 1ns/1ps
module pu_overlap_add
    import pitchup_pkg::*;
#(
    parameter int GAP = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  tap_t tap_i,
    output logic out_valid_o,
    output smp_t out_sample_o,
    output logic out_from_mem_o
);
    localparam int PTR_W = (GAP > 1) ? $clog2(GAP) : 1;
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(GAP - 1);

    smp_t             dly [GAP];
    logic [PTR_W-1:0] ptr;
    smp_t             old_val;

    assign old_val = dly[ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < GAP; k++) begin
                dly[k] <= '0;
            end
            ptr            <= '0;
            out_valid_o    <= 1'b0;
            out_sample_o   <= '0;
            out_from_mem_o <= 1'b0;
        end else begin
            out_valid_o <= tick_i;
            if (tick_i) begin
                dly[ptr]       <= tap_i.val;
                ptr            <= (ptr == LAST_PTR) ? '0 : ptr + 1'b1;
                out_sample_o   <= sat_add(tap_i.val, old_val);
                out_from_mem_o <= tap_i.from_mem;
            end
        end
    end

    AST_NO_WRAP_POS: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !tap_i.val[SMP_W-1] && !old_val[SMP_W-1]) |=> !out_sample_o[SMP_W-1]); // R7
    AST_NO_WRAP_NEG: assert property (@(posedge clk) disable iff (rst)
        (tick_i && tap_i.val[SMP_W-1] && old_val[SMP_W-1]) |=> out_sample_o[SMP_W-1]); // R7

endmodule

// File: rtl/pitchup_stage.sv
`timescale 1ns/1ps
module pitchup_stage
    import pitchup_pkg::*;
#(
    parameter int WIN_LEN     = 16,
    parameter int OVERLAP_PCT = 75
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic signed [SMP_W-1:0] in_sample,
    output logic                    out_valid,
    output logic signed [SMP_W-1:0] out_sample,
    output logic                    out_from_mem
);
    localparam int GAP   = gap_len(WIN_LEN, OVERLAP_PCT);
    localparam int RUN_W = $clog2(WIN_LEN + 1) + 1;

    logic tick;
    tap_t tap;

    pu_tick_gen #(.WIN(WIN_LEN), .GAP(GAP)) u_tick (
        .clk        (clk),
        .rst        (rst),
        .in_valid_i (in_valid),
        .tick_o     (tick)
    );

    pu_window_store #(.WIN(WIN_LEN)) u_store (
        .clk         (clk),
        .rst         (rst),
        .in_valid_i  (in_valid),
        .in_sample_i (in_sample),
        .tick_i      (tick),
        .tap_o       (tap)
    );

    pu_overlap_add #(.GAP(GAP)) u_sum (
        .clk            (clk),
        .rst            (rst),
        .tick_i         (tick),
        .tap_i          (tap),
        .out_valid_o    (out_valid),
        .out_sample_o   (out_sample),
        .out_from_mem_o (out_from_mem)
    );

    logic [RUN_W-1:0] mem_run;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_run <= '0;
        end else if (out_valid) begin
            mem_run <= out_from_mem ? mem_run + 1'b1 : '0;
        end
    end

    AST_MEM_RUN_LEN: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_from_mem) |-> (mem_run == 0 || mem_run == RUN_W'(WIN_LEN))); // R4
    AST_MEM_RUN_MAX: assert property (@(posedge clk) disable iff (rst)
        mem_run <= RUN_W'(WIN_LEN)); // R4

endmodule

// File: tb/pitchup_stage_tb_top.sv
`timescale 1ns/1ps
module pitchup_stage_tb_top;

    localparam int W = 16;
    localparam int D = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic               out_valid;
    logic signed [15:0] out_sample;
    logic               out_from_mem;

    int checks = 0;
    int fails  = 0;

    // model state
    int wr_buf [W];
    int pend_buf [W];
    int rd_buf [W];
    int wr_cnt, m_pending, m_reading, m_idx;
    int dl [D];
    int dptr;
    int mem_run, zero_run, steady;
    int n_out;
    int seen_max, seen_min;
    int garb;

    always #10 clk = ~clk;

    pitchup_stage #(.WIN_LEN(16), .OVERLAP_PCT(75)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .in_valid     (in_valid),
        .in_sample    (in_sample),
        .out_valid    (out_valid),
        .out_sample   (out_sample),
        .out_from_mem (out_from_mem)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sat16(input int v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    task automatic mdl_reset();
        wr_cnt = 0; m_pending = 0; m_reading = 0; m_idx = 0;
        for (int k = 0; k < D; k++) dl[k] = 0;
        dptr = 0; mem_run = 0; zero_run = 0; steady = 0;
    endtask

    task automatic observe();
        int s, fl, e;
        if (!out_valid) return;
        if (m_reading != 0) begin
            s = rd_buf[m_idx]; fl = 1; m_idx++;
            if (m_idx == W) m_reading = 0;
        end else if (m_pending != 0) begin
            rd_buf = pend_buf; s = rd_buf[0]; fl = 1;
            m_idx = 1; m_reading = 1; m_pending = 0;
        end else begin
            s = 0; fl = 0;
        end
        e = sat16(s + dl[dptr]);
        dl[dptr] = s;
        dptr = (dptr + 1) % D;
        if (e == 32767 || e == -32768)
            chk("R7 saturated sum", int'(out_sample), e);
        else
            chk("R6 overlap sum", int'(out_sample), e);
        chk(fl ? "R4 stored flag" : "R5 gap flag", int'(out_from_mem), fl);
        if (int'(out_sample) == 32767) seen_max = 1;
        if (int'(out_sample) == -32768) seen_min = 1;
        if (out_from_mem) begin
            if (zero_run > 0 && steady != 0) chk("R5 gap length", zero_run, D);
            zero_run = 0;
            mem_run++;
        end else begin
            if (mem_run > 0) begin
                chk("R4 window length", mem_run, W);
                steady = 1;
            end
            mem_run = 0;
            zero_run++;
        end
        n_out++;
    endtask

    task automatic cycle(input logic v, input logic signed [15:0] d);
        @(negedge clk);
        observe();
        in_valid  = v;
        in_sample = d;
        if (v) begin
            wr_buf[wr_cnt] = int'(d);
            wr_cnt++;
            if (wr_cnt == W) begin
                pend_buf = wr_buf; m_pending = 1; wr_cnt = 0;
            end
        end
    endtask

    task automatic send(input int d, input int spacing);
        cycle(1'b1, 16'(d));
        for (int k = 1; k < spacing; k++) begin
            garb = garb + 12345;
            cycle(1'b0, 16'(garb));
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) cycle(1'b0, 16'sh7fff);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        observe();
        rst = 1'b1; in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 out_valid in reset", int'(out_valid), 0);
        chk("R1 out_sample in reset", int'(out_sample), 0);
        chk("R1 out_from_mem in reset", int'(out_from_mem), 0);
        rst = 1'b0;
        mdl_reset();
        @(negedge clk);
        chk("R1 out_valid after reset", int'(out_valid), 0);
        chk("R1 out_sample after reset", int'(out_sample), 0);
    endtask

    task automatic t_reset();
        apply_reset();
    endtask

    task automatic t_ramps();
        int start;
        start = n_out;
        for (int w = 0; w < 4; w++)
            for (int i = 0; i < W; i++)
                send(w * 1000 + i * 37 - 200, 4);
        idle(5);
        chk("R3 strobe count ramps", n_out - start, 4 * (W + D));
    endtask

    task automatic t_ignored();
        int start, f0;
        start = n_out; f0 = fails;
        for (int w = 0; w < 3; w++)
            for (int i = 0; i < W; i++)
                send((i % 2 == 0) ? (100 + i * w) : -(300 + i), 7);
        idle(5);
        chk("R2 off-strobe data ignored", fails - f0, 0);
        chk("R3 strobe count spaced", n_out - start, 3 * (W + D));
    endtask

    task automatic t_saturate();
        seen_max = 0; seen_min = 0;
        for (int i = 0; i < W; i++) send(30000, 3);
        for (int i = 0; i < W; i++) send(-30000, 3);
        for (int i = 0; i < W; i++) send(20000 - i * 2500, 3);
        idle(5);
        chk("R7 positive clamp reached", seen_max, 1);
        chk("R7 negative clamp reached", seen_min, 1);
    endtask

    task automatic t_midreset();
        int start;
        for (int i = 0; i < 7; i++) send(9000 + i, 4);
        apply_reset();
        start = n_out;
        for (int w = 0; w < 3; w++)
            for (int i = 0; i < W; i++)
                send(-500 + w * 211 + i * 13, 5);
        idle(5);
        chk("R8 strobes after mid-window reset", n_out - start, 3 * (W + D));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        garb = 777;
        n_out = 0;
        seen_max = 0; seen_min = 0;
        mdl_reset();
        t_reset();
        t_ramps();
        t_ignored();
        t_saturate();
        t_midreset();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule